// File: doc/BRIEF.md
# Supply-Fail Write-Protect and Backup Switch Supervisor

This block watches the health of a memory's main supply through three digitized comparator flags. The flags say whether the supply is above the operating threshold, above the protect threshold and above the switchover threshold. From these flags it drives four outputs. The first is a write-protect signal that gates the memory strobes. The second is a force-high-impedance signal for the data outputs. The third is a select line that chooses between the backup source and the main supply. The fourth is a status bit that says the backup path has been armed.

Each raw flag goes through a two-flop synchronizer and a short glitch filter. Flags that contradict each other are resolved toward the more protective reading. A freshly built part starts sealed: the backup source stays disconnected until the supply first reaches the operating level. After that, a collapse below the switchover level selects backup power. Protection is lifted only after a recovery delay, counted in ticks, once the supply is valid again. The count starts over if the supply drops during that delay.

Top module: `sup_guard`

## Requirements
- R1: While reset is held and on the first cycle after it, write_protect=1, force_hiz=1, sel_backup=0 and backup_armed=0.
- R2: A raw flag change reaches the filtered flag only if it lasts FILT_LEN consecutive cycles after the two synchronizer stages. A shorter excursion leaves every output unchanged.
- R3: In normal operation, a loss of the operating flag raises write_protect and force_hiz combinationally, on the same edge where the filtered flag updates. That edge is FILT_LEN+2 edges after the raw change, before any state change.
- R4: Until the first valid-supply indication (sealed), sel_backup stays 0 and backup_armed stays 0 whatever the flags do, and write_protect stays 1.
- R5: The first valid-supply indication sets backup_armed to 1, and it stays 1 until reset.
- R6: Once armed, a resolved supply below the switchover level sets sel_backup=1 (backup power). A resolved supply at or above switchover sets sel_backup=0 (main power).
- R7: After the supply becomes valid again, write_protect stays 1 for REC_TICKS tick pulses. If the supply falls during that interval, the count restarts from zero.
- R8: Flags are resolved toward safety. The operating flag counts only when the protect and switchover flags are also 1. The protect flag counts only when the switchover flag is 1. Flag vector order is {switchover, protect, operating}.
- R9: After recovery completes with a valid supply, write_protect=0, force_hiz=0 and sel_backup=0. force_hiz always equals write_protect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse that advances the recovery delay |
| vop_ok_i | input | 1 | Raw flag: supply above the operating threshold |
| vprot_ok_i | input | 1 | Raw flag: supply above the protect threshold |
| vsw_ok_i | input | 1 | Raw flag: supply above the switchover threshold |
| wr_protect_o | output | 1 | Blocks memory strobes while high |
| force_hiz_o | output | 1 | Forces the data outputs to high impedance while high |
| sel_backup_o | output | 1 | 1 selects the backup source, 0 selects the main supply |
| backup_armed_o | output | 1 | 1 once the freshness seal has been broken |

## Verification
The hardest case to reach from the ports is a recovery interval cut short. The supply must first break the seal, then fail, then return. It must then drop again before the tick count completes, and the timer must be shown to restart rather than resume. The random stimulus holds each resolved supply level for either a short or a long window, chosen so that recovery is certainly unfinished or certainly finished. It never repeats a level back to back, so short valid windows followed by failures come up often. Directed sequences cover the seal, the exact latency of combinational protection, and a glitch shorter than the filter.

// File: rtl/sup_pkg.sv
package sup_pkg;

    typedef enum logic [2:0] {
        ST_SEALED     = 3'd0,
        ST_NORMAL     = 3'd1,
        ST_PROTECTED  = 3'd2,
        ST_BACKUP     = 3'd3,
        ST_RECOVERING = 3'd4
    } sup_state_e;

    typedef struct packed {
        logic sw_ok;
        logic prot_ok;
        logic op_ok;
    } supply_flags_t;

    localparam int NUM_FLAGS = 3;

    // Contradicting flags collapse toward the lower (safer) supply level
    function automatic supply_flags_t resolve_flags(supply_flags_t f);
        supply_flags_t r;
        r.sw_ok   = f.sw_ok;
        r.prot_ok = f.prot_ok & f.sw_ok;
        r.op_ok   = f.op_ok & f.prot_ok & f.sw_ok;
        return r;
    endfunction

endpackage

// File: rtl/sup_flag_filter.sv
module sup_flag_filter #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    output logic filt_o
);
    localparam int CW = (FILT_LEN < 2) ? 1 : $clog2(FILT_LEN + 1);
    localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

    logic          s1_q, s2_q;
    logic [CW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q   <= 1'b0;
            s2_q   <= 1'b0;
            run_q  <= '0;
            filt_o <= 1'b0;
        end else begin
            s1_q <= raw_i;
            s2_q <= s1_q;
            if (s2_q == filt_o) begin
                run_q <= '0;
            end else if (run_q == LAST) begin
                run_q  <= '0;
                filt_o <= s2_q;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sup_rec_timer.sv
module sup_rec_timer #(
    parameter int REC_TICKS = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    input  logic tick_i,
    output logic done_o
);
    localparam int CW = $clog2(REC_TICKS + 1);
    localparam logic [CW-1:0] LIM = CW'(REC_TICKS);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            cnt_q <= '0;
        end else if (tick_i && cnt_q != LIM) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done_o = (cnt_q == LIM);
endmodule

// File: rtl/sup_fsm.sv
module sup_fsm
    import sup_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  supply_flags_t flags_i,
    input  logic          done_i,
    output sup_state_e    state_o
);
    sup_state_e nxt;

    always_comb begin
        nxt = state_o;
        unique case (state_o)
            ST_SEALED:
                if (flags_i.op_ok) nxt = ST_RECOVERING;
            ST_NORMAL:
                if (!flags_i.sw_ok)      nxt = ST_BACKUP;
                else if (!flags_i.op_ok) nxt = ST_PROTECTED;
            ST_PROTECTED:
                if (!flags_i.sw_ok)     nxt = ST_BACKUP;
                else if (flags_i.op_ok) nxt = ST_RECOVERING;
            ST_BACKUP:
                if (flags_i.op_ok)      nxt = ST_RECOVERING;
                else if (flags_i.sw_ok) nxt = ST_PROTECTED;
            ST_RECOVERING:
                if (!flags_i.sw_ok)      nxt = ST_BACKUP;
                else if (!flags_i.op_ok) nxt = ST_PROTECTED;
                else if (done_i)         nxt = ST_NORMAL;
            default: nxt = ST_SEALED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_o <= ST_SEALED;
        else     state_o <= nxt;
    end
endmodule

// File: rtl/sup_guard.sv
module sup_guard
    import sup_pkg::*;
#(
    parameter int FILT_LEN  = 3,
    parameter int REC_TICKS = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic vop_ok_i,
    input  logic vprot_ok_i,
    input  logic vsw_ok_i,
    output logic wr_protect_o,
    output logic force_hiz_o,
    output logic sel_backup_o,
    output logic backup_armed_o
);
    logic [NUM_FLAGS-1:0] raw_vec, filt_vec;
    supply_flags_t        flags_res;
    sup_state_e           state;
    logic                 rec_done;
    logic                 op_ok_res;

    assign raw_vec = {vsw_ok_i, vprot_ok_i, vop_ok_i};

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        sup_flag_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk   (clk),
            .rst   (rst),
            .raw_i (raw_vec[i]),
            .filt_o(filt_vec[i])
        );
    end

    assign flags_res = resolve_flags(supply_flags_t'(filt_vec));
    assign op_ok_res = flags_res.op_ok;

    sup_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .flags_i(flags_res),
        .done_i (rec_done),
        .state_o(state)
    );

    sup_rec_timer #(.REC_TICKS(REC_TICKS)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .run_i (state == ST_RECOVERING),
        .tick_i(tick),
        .done_o(rec_done)
    );

    // The filtered fail flag blocks strobes before the state register reacts
    assign wr_protect_o   = (state != ST_NORMAL) || !op_ok_res;
    assign force_hiz_o    = wr_protect_o;
    assign sel_backup_o   = (state == ST_BACKUP);
    assign backup_armed_o = (state != ST_SEALED);
endmodule

// File: rtl/sup_guard_chk.sv
module sup_guard_chk (
    input logic clk,
    input logic rst,
    input logic wp,
    input logic hz,
    input logic sel,
    input logic armed,
    input logic op_ok
);
    // R9
    hiz_follows_wp_chk: assert property (@(posedge clk) disable iff (rst)
        hz == wp);

    // R4
    sel_needs_arm_chk: assert property (@(posedge clk) disable iff (rst)
        sel |-> armed);

    // R5
    arm_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        armed |=> armed);

    // R6
    backup_protected_chk: assert property (@(posedge clk) disable iff (rst)
        sel |-> wp);

    // R7
    release_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(wp) |-> op_ok);
endmodule

bind sup_guard sup_guard_chk u_chk (
    .clk  (clk),
    .rst  (rst),
    .wp   (wr_protect_o),
    .hz   (force_hiz_o),
    .sel  (sel_backup_o),
    .armed(backup_armed_o),
    .op_ok(op_ok_res)
);

// File: tb/sim_sup_guard.sv
module sim_sup_guard;
    localparam int FILT = 3;
    localparam int RECT = 5;
    localparam int SHORT_H = 14;
    localparam int LONG_H  = 40;
    localparam int M_SEAL = 0, M_NORM = 1, M_PROT = 2, M_BACK = 3, M_REC = 4;

    logic clk = 0, rst = 1, tick = 0;
    logic vop = 0, vprot = 0, vsw = 0;
    logic wp, hz, sel, armed;
    int compared = 0, mismatched = 0;
    int mstate = M_SEAL;
    bit finished = 0;
    int tcnt = 0;

    always #10 clk = ~clk;

    always_ff @(posedge clk) begin
        tcnt <= (tcnt == 3) ? 0 : tcnt + 1;
        tick <= (tcnt == 3);
    end

    sup_guard #(.FILT_LEN(FILT), .REC_TICKS(RECT)) u0 (
        .clk(clk), .rst(rst), .tick(tick),
        .vop_ok_i(vop), .vprot_ok_i(vprot), .vsw_ok_i(vsw),
        .wr_protect_o(wp), .force_hiz_o(hz),
        .sel_backup_o(sel), .backup_armed_o(armed)
    );

    // Resolved level per R8: 0 below switchover, 1 below protect, 2 below operating, 3 valid
    function automatic int level_of(logic [2:0] f);
        if (!f[2]) return 0;
        if (!f[1]) return 1;
        if (!f[0]) return 2;
        return 3;
    endfunction

    function automatic int next_model(int st, int lvl, bit long_hold);
        if (st == M_SEAL && lvl != 3) return M_SEAL;
        if (lvl == 0) return M_BACK;
        if (lvl < 3)  return M_PROT;
        if (st == M_NORM) return M_NORM;
        return long_hold ? M_NORM : M_REC;
    endfunction

    task automatic chk(string req, logic got, logic exp, string what);
        compared++;
        if (got !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %b expected %b", req, what, got, exp);
        end
    endtask

    task automatic chk_model(string req);
        chk(req, wp,    mstate != M_NORM, "write_protect");
        chk(req, hz,    mstate != M_NORM, "force_hiz");
        chk(req, sel,   mstate == M_BACK, "sel_backup");
        chk(req, armed, mstate != M_SEAL, "backup_armed");
    endtask

    task automatic drive(logic [2:0] f);
        {vsw, vprot, vop} = f;
    endtask

    task automatic segment(logic [2:0] f, bit long_hold, string req);
        drive(f);
        repeat (long_hold ? LONG_H : SHORT_H) @(negedge clk);
        mstate = next_model(mstate, level_of(f), long_hold);
        chk_model(req);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin : main
        int prev_lvl;
        logic [2:0] f;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: during reset
        chk("R1", wp, 1'b1, "wp in reset");
        chk("R1", armed, 1'b0, "armed in reset");
        rst = 0;
        @(negedge clk);
        chk_model("R1");

        // R4: sealed ignores every sub-valid level including below switchover
        segment(3'b000, 1'b1, "R4");
        segment(3'b100, 1'b0, "R4");
        segment(3'b110, 1'b0, "R4");
        // R8: operating flag without the others stays sealed
        segment(3'b001, 1'b0, "R8");

        // R5 / R7: first valid indication, still recovering after a short hold
        segment(3'b111, 1'b0, "R5");
        // R7: drop during recovery, then return briefly: count restarted
        segment(3'b110, 1'b0, "R7");
        segment(3'b111, 1'b0, "R7");
        // R9: long hold completes recovery
        segment(3'b111, 1'b1, "R9");

        // R2: two-cycle glitch on the operating flag is filtered
        drive(3'b110);
        @(negedge clk); @(negedge clk);
        drive(3'b111);
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            chk("R2", wp, 1'b0, "wp during glitch");
        end

        // R3: combinational protect exactly FILT+2 edges after raw loss
        drive(3'b110);
        repeat (FILT + 1) @(negedge clk);
        chk("R3", wp, 1'b0, "wp one edge early");
        @(negedge clk);
        chk("R3", wp, 1'b1, "wp at filter edge");
        chk("R3", hz, 1'b1, "hiz at filter edge");
        repeat (SHORT_H) @(negedge clk);
        mstate = M_PROT;
        chk_model("R3");

        // R6: below switchover selects backup, return to main above it
        segment(3'b000, 1'b0, "R6");
        segment(3'b100, 1'b0, "R6");
        // R8: inconsistent vector resolves low
        segment(3'b011, 1'b0, "R8");
        segment(3'b101, 1'b1, "R8");

        // Random levels, never repeating the resolved level back to back
        prev_lvl = 2;
        for (int n = 0; n < 70; n++) begin
            bit lh;
            do f = 3'($urandom_range(0, 7)); while (level_of(f) == prev_lvl);
            prev_lvl = level_of(f);
            lh = ($urandom_range(0, 1) == 1);
            segment(f, lh, (prev_lvl == 0) ? "R6" : (prev_lvl == 3) ? "R7" : "R8");
        end

        // R5: reset returns the seal
        rst = 1;
        @(negedge clk);
        rst = 0;
        drive(3'b000);
        mstate = M_SEAL;
        repeat (SHORT_H) @(negedge clk);
        chk_model("R5");

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule